// File: doc/BRIEF.md
# NOR Flash Command Interface Emulator

This block is a synchronous model of a 32-bit NOR flash array. The array is two 16-bit halves side by side. Each half has its own command state machine, status byte, lock bits and storage. Both halves are addressed by the same word address and see the same bus access. Each half decodes the command carried in its own 16-bit lane of the write data. Only the low byte of each lane is decoded as a command. While a half is in array mode, reads return its stored contents, so the array behaves as ROM. Every write is a command or the data that completes one.

Program, erase and lock operations complete in the cycle that accepts their final write, so the ready flag in the status byte never drops. The command set covers the following: read array (0xFF), read status (0x70), clear status (0x50), program setup (0x40 or 0x10), erase setup (0x20), lock setup (0x60), confirm (0xD0), lock (0x01) and query (0x98). Suspend (0xB0) and resume (0xD0 outside a setup state) are taken and ignored. Parameters select three things: overwrite versus bit-clearing program, per-block locking, and a trap mode in which every write is refused with a bus error.

The slave port uses valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the next cycle with `resp_valid` high. `req_ready` is low only while a response is waiting and `resp_ready` is low. A waiting response keeps its data and error bit until it is taken. A new request can be accepted in the same cycle that a waiting response is consumed.

Top module: `nor_cmd_emu`

## Requirements
- R1: While `resp_valid` is high and `resp_ready` is low, `req_ready` is low and `resp_rdata`/`resp_err` hold their values. A request is accepted in the same cycle that the waiting response is taken.
- R2: After reset, every half is in array mode and every stored word reads 0xFFFFFFFF. A read in array mode returns the stored word at `req_addr`.
- R3: In status mode each lane reads 0x00 in its upper byte. Its lower byte holds the status byte, with bit 7 (ready) always 1, bit 5 erase error, bit 4 program error and bit 1 locked-block error.
- R4: A program setup (0x40 or 0x10) followed by a data write stores that lane's data at the data write's address, replacing the old value when OVERWRITE=1. The half then enters status mode.
- R5: With OVERWRITE=0, a program stores the old value ANDed with the data, so no bit can change from 0 to 1.
- R6: Erase setup 0x20 followed by 0xD0 sets every word of the addressed block (word address bits above BLK_AW) to all ones and leaves other blocks unchanged. Any other second byte sets bits 5 and 4, erases nothing and enters status mode.
- R7: With BLOCK_LOCK=1, the sequence 0x60 then 0x01 locks the addressed block, and 0x60 then 0xD0 unlocks it. A program to a locked block is rejected and sets bits 4 and 1. An erase of a locked block is rejected and sets bits 5 and 1. With BLOCK_LOCK=0, the lock sequence has no effect. Any other second byte after 0x60 sets bits 5 and 4.
- R8: Error bits stay set until a clear status (0x50), which clears them without changing the mode.
- R9: A read while a half waits for program data, an erase confirm or a lock confirm returns 0xDEAD in that lane.
- R10: In query mode, word offsets 0x10, 0x11 and 0x12 read 0x51, 0x52 and 0x59, and offset 0x27 reads log2 of the half's size in bytes. Offset 0x2D reads the low byte and offset 0x2E the high byte of the block count minus one. Other offsets read 0.
- R11: Suspend 0xB0, resume 0xD0 and unknown commands leave mode and contents unchanged. 0xFF returns to array mode.
- R12: With TRAP=1, every accepted write gets `resp_err`=1 and changes nothing. Reads still return array data with `resp_err`=0. With TRAP=0, `resp_err` is always 0.
- R13: The two halves follow their own lane's commands independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write (command/data), 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 32 | Write data, lane 0 in bits 15:0 |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Response taken this cycle |
| resp_rdata | output | 32 | Read data |
| resp_err | output | 1 | Write refused (trap mode) |

## Verification
The hardest situation to reach is a half in a different mode from its neighbour. Because both halves share one bus access, the stimulus has to put a different command byte in each 16-bit lane of a single write, for example read status in one lane and query in the other. The stimulus then checks that one read returns a status byte in one lane and a query byte in the other. Locked-block rejection is also only visible indirectly. It is reached by locking a block and then attempting both a program and an erase on it. The error flags are read through status mode, and the untouched contents are read back after returning to array mode.

// File: rtl/nor_emu_pkg.sv
package nor_emu_pkg;

  typedef enum logic [2:0] {
    LS_ARRAY,
    LS_STATUS,
    LS_QUERY,
    LS_PROG,
    LS_ERASE,
    LS_LOCK
  } lane_st_e;

  localparam logic [7:0] OP_READ    = 8'hFF;
  localparam logic [7:0] OP_RSTAT   = 8'h70;
  localparam logic [7:0] OP_CLR     = 8'h50;
  localparam logic [7:0] OP_PROG_A  = 8'h40;
  localparam logic [7:0] OP_PROG_B  = 8'h10;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_LOCKSU  = 8'h60;
  localparam logic [7:0] OP_LOCKSET = 8'h01;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_QUERY   = 8'h98;

  localparam int SB_RDY = 7;
  localparam int SB_ERS = 5;
  localparam int SB_PRG = 4;
  localparam int SB_LCK = 1;

  localparam logic [15:0] POISON16 = 16'hDEAD;

  function automatic logic [15:0] query_word(input logic [7:0] idx,
                                             input logic [7:0] size_log2,
                                             input logic [15:0] blk_max);
    case (idx)
      8'h10:   return 16'h0051;
      8'h11:   return 16'h0052;
      8'h12:   return 16'h0059;
      8'h27:   return {8'h00, size_log2};
      8'h2D:   return {8'h00, blk_max[7:0]};
      8'h2E:   return {8'h00, blk_max[15:8]};
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/nor_resp_ctrl.sv
module nor_resp_ctrl #(
  parameter bit TRAP = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic resp_ready,
  output logic req_ready,
  output logic acc,
  output logic resp_valid,
  output logic resp_err
);

  assign req_ready = !resp_valid || resp_ready;
  assign acc       = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
    end else if (acc) begin
      resp_valid <= 1'b1;
      resp_err   <= TRAP && req_write;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  // R1: a waiting response is not dropped and keeps its error bit
  p_hold_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_err));

  // R12: without trap mode no response carries an error
  p_no_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !TRAP |-> !resp_err);

endmodule

// File: rtl/nor_lane.sv
module nor_lane
  import nor_emu_pkg::*;
#(
  parameter int AW         = 6,
  parameter int BLK_AW     = 4,
  parameter bit OVERWRITE  = 1'b1,
  parameter bit BLOCK_LOCK = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata
);

  localparam int WORDS     = 1 << AW;
  localparam int BLK_W     = AW - BLK_AW;
  localparam int NUM_BLK   = 1 << BLK_W;
  localparam int BLK_WORDS = 1 << BLK_AW;
  localparam logic [7:0]  SIZE_LOG2 = 8'(AW + 1);
  localparam logic [15:0] BLK_MAX   = 16'(NUM_BLK - 1);

  lane_st_e          st;
  logic [7:0]        err;
  logic [NUM_BLK-1:0] lock;
  logic [15:0]       mem [WORDS];

  logic [BLK_W-1:0]  blk;
  logic [7:0]        op;
  logic              lock_hit;
  logic              cmd_st;
  logic [15:0]       rd_mux;

  assign blk      = addr[AW-1:BLK_AW];
  assign op       = wdata[7:0];
  assign lock_hit = BLOCK_LOCK && lock[blk];
  assign cmd_st   = (st == LS_ARRAY) || (st == LS_STATUS) || (st == LS_QUERY);

  always_comb begin
    case (st)
      LS_ARRAY:  rd_mux = mem[addr];
      LS_STATUS: rd_mux = {8'h00, err | 8'h80};
      LS_QUERY:  rd_mux = query_word(8'(addr), SIZE_LOG2, BLK_MAX);
      default:   rd_mux = POISON16;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= LS_ARRAY;
      err   <= '0;
      lock  <= '0;
      rdata <= '0;
      for (int i = 0; i < WORDS; i++) mem[AW'(i)] <= '1;
    end else if (acc) begin
      if (!wr) begin
        rdata <= rd_mux;
      end else begin
        case (st)
          LS_PROG: begin
            if (lock_hit) begin
              err[SB_PRG] <= 1'b1;
              err[SB_LCK] <= 1'b1;
            end else if (OVERWRITE) begin
              mem[addr] <= wdata;
            end else begin
              mem[addr] <= mem[addr] & wdata;
            end
            st <= LS_STATUS;
          end
          LS_ERASE: begin
            if (op != OP_CONFIRM) begin
              err[SB_ERS] <= 1'b1;
              err[SB_PRG] <= 1'b1;
            end else if (lock_hit) begin
              err[SB_ERS] <= 1'b1;
              err[SB_LCK] <= 1'b1;
            end else begin
              for (int i = 0; i < BLK_WORDS; i++) mem[{blk, BLK_AW'(i)}] <= '1;
            end
            st <= LS_STATUS;
          end
          LS_LOCK: begin
            if (op == OP_LOCKSET) begin
              if (BLOCK_LOCK) lock[blk] <= 1'b1;
            end else if (op == OP_CONFIRM) begin
              if (BLOCK_LOCK) lock[blk] <= 1'b0;
            end else begin
              err[SB_ERS] <= 1'b1;
              err[SB_PRG] <= 1'b1;
            end
            st <= LS_STATUS;
          end
          default: begin
            case (op)
              OP_READ:              st  <= LS_ARRAY;
              OP_RSTAT:             st  <= LS_STATUS;
              OP_CLR:               err <= '0;
              OP_PROG_A, OP_PROG_B: st  <= LS_PROG;
              OP_ERASE:             st  <= LS_ERASE;
              OP_LOCKSU:            st  <= LS_LOCK;
              OP_QUERY:             st  <= LS_QUERY;
              default:              ;
            endcase
          end
        endcase
      end
    end
  end

  // R7: a rejected program leaves the target word as it was
  p_lock_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && wr && st == LS_PROG && lock_hit |=> mem[$past(addr)] == $past(mem[addr]));

  // R8: error flags only grow until a clear-status command
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err != 0 && !(acc && wr && cmd_st && op == OP_CLR) |=> (err & $past(err)) == $past(err));

  // R9: reads in setup states return the poison half-word
  p_poison_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !wr && !cmd_st |=> rdata == POISON16);

  // R6: a confirmed erase leaves the block base word all ones
  p_erase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && wr && st == LS_ERASE && op == OP_CONFIRM && !lock_hit
    |=> mem[{$past(blk), BLK_AW'(0)}] == 16'hFFFF);

  generate
    if (!OVERWRITE) begin : g_and_chk
      // R5: bit-clearing program never raises a bit
      p_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc && wr && st == LS_PROG |=> (mem[$past(addr)] & ~$past(mem[addr])) == 16'h0000);
    end
  endgenerate

endmodule

// File: rtl/nor_cmd_emu.sv
module nor_cmd_emu #(
  parameter int AW         = 6,
  parameter int BLK_AW     = 4,
  parameter bit OVERWRITE  = 1'b1,
  parameter bit BLOCK_LOCK = 1'b0,
  parameter bit TRAP       = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic [31:0]   resp_rdata,
  output logic          resp_err
);

  localparam int LANES = 2;

  logic acc;
  logic lane_acc;

  nor_resp_ctrl #(.TRAP(TRAP)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .resp_ready (resp_ready),
    .req_ready  (req_ready),
    .acc        (acc),
    .resp_valid (resp_valid),
    .resp_err   (resp_err)
  );

  assign lane_acc = acc && !(TRAP && req_write);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      nor_lane #(
        .AW         (AW),
        .BLK_AW     (BLK_AW),
        .OVERWRITE  (OVERWRITE),
        .BLOCK_LOCK (BLOCK_LOCK)
      ) u_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (lane_acc),
        .wr    (req_write),
        .addr  (req_addr),
        .wdata (req_wdata[16*g +: 16]),
        .rdata (resp_rdata[16*g +: 16])
      );
    end
  endgenerate

  // R1: read data is held while the response waits
  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> $stable(resp_rdata));

  // R12: a trapped write is answered with an error
  p_trap_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
    TRAP && acc && req_write |=> resp_valid && resp_err);

endmodule

// File: tb/nor_cmd_emu_tb_top.sv
`timescale 1ns/100ps
module nor_cmd_emu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        resp_ready = 1'b1;

  logic        m_ready, a_ready, t_ready;
  logic        m_valid, a_valid, t_valid;
  logic [31:0] m_rdata, a_rdata, t_rdata;
  logic        m_err, a_err, t_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nor_cmd_emu #(.OVERWRITE(1'b1), .BLOCK_LOCK(1'b1), .TRAP(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(m_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(m_valid), .resp_ready(resp_ready), .resp_rdata(m_rdata), .resp_err(m_err));

  nor_cmd_emu #(.OVERWRITE(1'b0), .BLOCK_LOCK(1'b0), .TRAP(1'b0)) dut_and_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(a_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(a_valid), .resp_ready(resp_ready), .resp_rdata(a_rdata), .resp_err(a_err));

  nor_cmd_emu #(.OVERWRITE(1'b1), .BLOCK_LOCK(1'b0), .TRAP(1'b1)) dut_trap_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(t_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(t_valid), .resp_ready(resp_ready), .resp_rdata(t_rdata), .resp_err(t_err));

  // {write, addr, data, expected read of dut_i}
  localparam int NV = 64;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h0, 32'hFFFFFFFF},        // R2 erased after reset
    {1'b1, 8'h05, 32'h00400040, 32'h0},        // R4 program setup
    {1'b0, 8'h05, 32'h0, 32'hDEADDEAD},        // R9
    {1'b1, 8'h05, 32'h12345678, 32'h0},        // R4 data
    {1'b0, 8'h05, 32'h0, 32'h00800080},        // R3 status ready
    {1'b1, 8'h00, 32'h00FF00FF, 32'h0},
    {1'b0, 8'h05, 32'h0, 32'h12345678},        // R4 stored
    {1'b1, 8'h05, 32'h00100010, 32'h0},        // R4 alternate setup
    {1'b1, 8'h05, 32'h0000FFFF, 32'h0},
    {1'b1, 8'h00, 32'h00FF00FF, 32'h0},
    {1'b0, 8'h05, 32'h0, 32'h0000FFFF},        // R4 overwrite raises bits
    {1'b1, 8'h15, 32'h00400040, 32'h0},
    {1'b1, 8'h15, 32'hA5A5A5A5, 32'h0},
    {1'b1, 8'h03, 32'h00200020, 32'h0},        // R6 erase setup
    {1'b0, 8'h03, 32'h0, 32'hDEADDEAD},        // R9
    {1'b1, 8'h03, 32'h00D000D0, 32'h0},
    {1'b1, 8'h00, 32'h00FF00FF, 32'h0},
    {1'b0, 8'h05, 32'h0, 32'hFFFFFFFF},        // R6 block 0 erased
    {1'b0, 8'h15, 32'h0, 32'hA5A5A5A5},        // R6 block 1 kept
    {1'b1, 8'h10, 32'h00200020, 32'h0},
    {1'b1, 8'h10, 32'h00FF00FF, 32'h0},        // R6 bad confirm
    {1'b0, 8'h10, 32'h0, 32'h00B000B0},        // R6 bits 5,4
    {1'b1, 8'h00, 32'h00700070, 32'h0},
    {1'b0, 8'h00, 32'h0, 32'h00B000B0},        // R8 sticky
    {1'b1, 8'h00, 32'h00500050, 32'h0},
    {1'b0, 8'h00, 32'h0, 32'h00800080},        // R8 cleared, still status
    {1'b1, 8'h00, 32'h00980098, 32'h0},        // R10 query
    {1'b0, 8'h10, 32'h0, 32'h00510051},
    {1'b0, 8'h11, 32'h0, 32'h00520052},
    {1'b0, 8'h12, 32'h0, 32'h00590059},
    {1'b0, 8'h27, 32'h0, 32'h00070007},
    {1'b0, 8'h2D, 32'h0, 32'h00030003},
    {1'b0, 8'h2E, 32'h0, 32'h00000000},
    {1'b1, 8'h00, 32'h00B000B0, 32'h0},        // R11 suspend
    {1'b0, 8'h10, 32'h0, 32'h00510051},
    {1'b1, 8'h00, 32'h00D000D0, 32'h0},        // R11 resume
    {1'b0, 8'h10, 32'h0, 32'h00510051},
    {1'b1, 8'h00, 32'h00FF00FF, 32'h0},
    {1'b0, 8'h15, 32'h0, 32'hA5A5A5A5},        // R11 back to array
    {1'b1, 8'h00, 32'h00700098, 32'h0},        // R13 split command
    {1'b0, 8'h10, 32'h0, 32'h00800051},        // R13 status | query
    {1'b1, 8'h00, 32'h00FF00FF, 32'h0},
    {1'b1, 8'h20, 32'h00600060, 32'h0},        // R7 lock setup
    {1'b0, 8'h20, 32'h0, 32'hDEADDEAD},        // R9
    {1'b1, 8'h20, 32'h00010001, 32'h0},        // R7 lock block 2
    {1'b1, 8'h22, 32'h00400040, 32'h0},
    {1'b1, 8'h22, 32'h00000000, 32'h0},
    {1'b0, 8'h22, 32'h0, 32'h00920092},        // R7 program rejected
    {1'b1, 8'h00, 32'h00500050, 32'h0},
    {1'b1, 8'h00, 32'h00FF00FF, 32'h0},
    {1'b0, 8'h22, 32'h0, 32'hFFFFFFFF},        // R7 word kept
    {1'b1, 8'h20, 32'h00200020, 32'h0},
    {1'b1, 8'h20, 32'h00D000D0, 32'h0},
    {1'b0, 8'h20, 32'h0, 32'h00A200A2},        // R7 erase rejected
    {1'b1, 8'h00, 32'h00500050, 32'h0},
    {1'b1, 8'h20, 32'h00600060, 32'h0},
    {1'b1, 8'h20, 32'h00D000D0, 32'h0},        // R7 unlock
    {1'b1, 8'h22, 32'h00400040, 32'h0},
    {1'b1, 8'h22, 32'hCAFEF00D, 32'h0},
    {1'b1, 8'h00, 32'h00FF00FF, 32'h0},
    {1'b0, 8'h22, 32'h0, 32'hCAFEF00D},        // R7 program after unlock
    {1'b1, 8'h30, 32'h00600060, 32'h0},
    {1'b1, 8'h30, 32'h00770077, 32'h0},        // R7 bad lock confirm
    {1'b0, 8'h30, 32'h0, 32'h00B000B0}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic xact(input logic w, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ready", {31'b0, m_ready}, 32'd1);
    chk("R1 reset valid", {31'b0, m_valid}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      xact(VEC[i][72], 6'(VEC[i][71:64]), VEC[i][63:32]);
      if (VEC[i][72]) begin
        chk($sformatf("R12 vector %0d trap err", i), {31'b0, t_err}, 32'd1);
        chk($sformatf("R12 vector %0d main err", i), {31'b0, m_err}, 32'd0);
      end else begin
        chk($sformatf("R2 vector %0d read", i), m_rdata, VEC[i][31:0]);
      end
    end
    xact(1'b1, 6'h00, 32'h00500050);
    xact(1'b1, 6'h00, 32'h00FF00FF);

    // R7 with locking disabled, R5 bit-clearing program
    xact(1'b1, 6'h30, 32'h00600060);
    xact(1'b1, 6'h30, 32'h00010001);
    xact(1'b1, 6'h31, 32'h00400040);
    xact(1'b1, 6'h31, 32'h0F0F0F0F);
    xact(1'b0, 6'h31, 32'h0);
    chk("R7 locked status", m_rdata, 32'h00920092);
    chk("R7 lock ignored status", a_rdata, 32'h00800080);
    xact(1'b1, 6'h00, 32'h00500050);
    xact(1'b1, 6'h00, 32'h00FF00FF);
    xact(1'b0, 6'h31, 32'h0);
    chk("R7 locked word kept", m_rdata, 32'hFFFFFFFF);
    chk("R7 lock ignored word", a_rdata, 32'h0F0F0F0F);
    xact(1'b1, 6'h31, 32'h00400040);
    xact(1'b1, 6'h31, 32'hF0F0FFFF);
    xact(1'b1, 6'h00, 32'h00FF00FF);
    xact(1'b0, 6'h31, 32'h0);
    chk("R5 AND program", a_rdata, 32'h00000F0F);
    xact(1'b1, 6'h00, 32'h00500050);
    xact(1'b0, 6'h22, 32'h0);
    chk("R12 trap read data", t_rdata, 32'hFFFFFFFF);
    chk("R12 trap read err", {31'b0, t_err}, 32'd0);

    // R1 back-pressure
    @(negedge clk);
    resp_ready = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_addr = 6'h22;
    @(negedge clk);
    chk("R1 valid", {31'b0, m_valid}, 32'd1);
    chk("R1 data", m_rdata, 32'hCAFEF00D);
    req_addr = 6'h31;
    repeat (2) @(negedge clk);
    chk("R1 stalled ready", {31'b0, m_ready}, 32'd0);
    chk("R1 held data", m_rdata, 32'hCAFEF00D);
    resp_ready = 1'b1;
    @(negedge clk);
    chk("R1 next valid", {31'b0, m_valid}, 32'd1);
    chk("R1 next data", m_rdata, 32'hFFFFFFFF);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R1 drained", {31'b0, m_valid}, 32'd0);

    // R2 reset restores erased array
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 reset valid", {31'b0, m_valid}, 32'd0);
    rst_n = 1'b1;
    xact(1'b0, 6'h22, 32'h0);
    chk("R2 reset contents", m_rdata, 32'hFFFFFFFF);

    finish_run();
  end

endmodule